// File: doc/BRIEF.md
# Four-Channel Phase-Coherent Sine Synthesizer Core

This core holds four numerically controlled oscillators that all run from one system clock. Each channel keeps a 32-bit phase accumulator. Every clock the accumulator advances by the channel's frequency tuning word, so the output frequency is the tuning word times the clock rate divided by 2^32. A 14-bit phase offset, given in fractions of a turn, is added to the upper accumulator bits. The top 12 bits of that sum address a quarter-wave sine table that is computed into the logic. An optional 10-bit scale word can then attenuate the signed sample.

The tuning words, offsets and scale settings are presented on staged input buses. They become active for all channels together, and only on a clock edge where the update strobe is high. A shared clear input zeroes every accumulator on the same edge, so channels that are programmed together start from a common phase and stay aligned.

The samples leave on a free-running bus with one new value per channel every clock. There is no back-pressure on that bus and no valid qualifier, so a consumer must take each sample as it appears. All control pins are plain levels sampled at the rising edge.

Top module: `dds4_core`

## Requirements
- R1: On each rising edge where acc_clr is low, each channel's accumulator becomes its previous value plus that channel's active tuning word, modulo 2^32.
- R2: The offset phase is (accumulator bits 31..18 + active 14-bit offset) modulo 2^14. Its upper 12 bits form the table address A: A[11:10] is the quadrant and A[9:0] is the index k.
- R3: The table magnitude for index i is floor(511*sin(pi*(2i+1)/4096)+0.5). Quadrants 0 and 2 use i=k, and quadrants 1 and 3 use i=1023-k. Quadrants 2 and 3 negate the result. Each sample is a 10-bit two's complement value that never equals -512, and channel c sits at sample_out[c*10 +: 10].
- R4: When a channel's active scale enable is 0, its output equals the unscaled table sample, whatever the scale word holds.
- R5: When a channel's active scale enable is 1, its output is the sign of the sample applied to floor(|sample|*scale/1024), which rounds toward zero. A scale of 0x3FF turns 511 into 510, and a scale of 0 gives 0.
- R6: The active settings of all channels load from the staged buses on an edge with cfg_update high. Without that strobe they keep their values, and changes on the staged buses have no effect on the outputs.
- R7: An edge with acc_clr high sets all four accumulators to zero on that same edge, and this takes priority over advancing.
- R8: The output after edge n+3 is the sample for the accumulator value after edge n. This latency is the same for every channel, so channels with equal settings produce identical samples.
- R9: While rst_n is low, the accumulators, the active settings and the pipeline are all zero. The first output after reset is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by all channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_clr | input | 1 | Synchronous clear of all accumulators |
| cfg_update | input | 1 | Loads staged settings into the active set |
| stage_ftw | input | 128 | Staged tuning words, channel c at [c*32 +: 32] |
| stage_pow | input | 56 | Staged phase offsets, channel c at [c*14 +: 14] |
| stage_amp | input | 40 | Staged scale words, channel c at [c*10 +: 10] |
| stage_amp_en | input | 4 | Staged scale enables, bit c for channel c |
| sample_out | output | 40 | Signed samples, channel c at [c*10 +: 10] |

## Verification
The bench first drives zero tuning words with quarter-turn offsets. These constant outputs separate the four quadrant folds and the sign handling, and they also show the scale bypass against scale values 0x3FF, 0x200 and 0. A tuning word of a quarter turn, a half turn or all ones steps through the table in known hops, which exposes errors in accumulator wrap, in address bit selection and in pipeline latency. Random tuning words, offsets and scale settings are then compared every cycle against a bench model of the whole chain. In one random round two channels carry the same settings, which checks that the channels stay coherent. In another round the staged buses change without an update, which shows that unlatched values are ignored.

// File: rtl/dds4_pkg.sv
package dds4_pkg;
  localparam int unsigned DEF_ACC_W  = 32;
  localparam int unsigned DEF_POFF_W = 14;
  localparam int unsigned DEF_ADDR_W = 12;
  localparam int unsigned DEF_AMP_W  = 10;
  localparam int unsigned DEF_OUT_W  = 10;

  // Rounded magnitude of a quarter-wave entry sampled at the centre of its bin.
  function automatic int quarter_sine(input int idx, input int idx_bits, input int peak);
    real ang;
    real steps;
    steps = real'(64'd1 << idx_bits);
    ang = 3.14159265358979323846 * (2.0 * idx + 1.0) / (4.0 * steps);
    return $rtoi($floor(peak * $sin(ang) + 0.5));
  endfunction
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned POFF_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [ACC_W-1:0]  ftw,
  input  logic [POFF_W-1:0] pow,
  output logic [ACC_W-1:0]  acc_o,
  output logic [POFF_W-1:0] phase_o
);
  logic [ACC_W-1:0]  acc_q;
  logic [POFF_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ph_q  <= '0;
    end else begin
      acc_q <= clr ? '0 : acc_q + ftw;
      ph_q  <= acc_q[ACC_W-1 -: POFF_W] + pow;
    end
  end

  assign acc_o   = acc_q;
  assign phase_o = ph_q;
endmodule

// File: rtl/dds_sine_lut.sv
module dds_sine_lut #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned OUT_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [OUT_W-1:0] sample_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam int unsigned MAG_W = OUT_W - 1;
  localparam int          PEAK  = (1 << MAG_W) - 1;

  logic [MAG_W-1:0] rom [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
    localparam int VAL = dds4_pkg::quarter_sine(gi, IDX_W, PEAK);
    assign rom[gi] = MAG_W'(VAL);
  end

  logic [1:0]              quad;
  logic [IDX_W-1:0]        k;
  logic [IDX_W-1:0]        idx;
  logic signed [OUT_W-1:0] mag_s;
  logic signed [OUT_W-1:0] nxt;

  always_comb begin
    quad  = addr[ADDR_W-1 -: 2];
    k     = addr[IDX_W-1:0];
    idx   = quad[0] ? ~k : k;
    mag_s = $signed({1'b0, rom[idx]});
    nxt   = quad[1] ? -mag_s : mag_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_o <= '0;
    else        sample_o <= nxt;
  end
endmodule

// File: rtl/dds_amp_scale.sv
module dds_amp_scale #(
  parameter int unsigned IN_W  = 10,
  parameter int unsigned AMP_W = 10
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic signed [IN_W-1:0] sample_i,
  input  logic                   en,
  input  logic [AMP_W-1:0]       amp,
  output logic signed [IN_W-1:0] sample_o
);
  localparam int unsigned PROD_W = IN_W + AMP_W;

  logic                   neg;
  logic [IN_W-1:0]        magn;
  logic [PROD_W-1:0]      prod;
  logic [IN_W-1:0]        shr;
  logic signed [IN_W-1:0] scaled;

  always_comb begin
    neg    = sample_i[IN_W-1];
    magn   = neg ? IN_W'(-sample_i) : IN_W'(sample_i);
    prod   = {{AMP_W{1'b0}}, magn} * {{IN_W{1'b0}}, amp};
    shr    = prod[AMP_W +: IN_W];
    scaled = neg ? -$signed(shr) : $signed(shr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_o <= '0;
    else        sample_o <= en ? scaled : sample_i;
  end
endmodule

// File: rtl/dds_channel.sv
module dds_channel #(
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned POFF_W = 14,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned AMP_W  = 10,
  parameter int unsigned OUT_W  = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [ACC_W-1:0]        ftw,
  input  logic [POFF_W-1:0]       pow,
  input  logic                    amp_en,
  input  logic [AMP_W-1:0]        amp,
  output logic [ACC_W-1:0]        acc_o,
  output logic signed [OUT_W-1:0] sample_o
);
  logic [POFF_W-1:0]       phase;
  logic signed [OUT_W-1:0] raw;
  // scale settings travel beside the phase so all stages see one setting
  logic                    en_s1, en_s2;
  logic [AMP_W-1:0]        amp_s1, amp_s2;

  dds_phase_acc #(.ACC_W(ACC_W), .POFF_W(POFF_W)) i_acc (
    .clk(clk), .rst_n(rst_n), .clr(clr), .ftw(ftw), .pow(pow),
    .acc_o(acc_o), .phase_o(phase)
  );

  dds_sine_lut #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) i_lut (
    .clk(clk), .rst_n(rst_n), .addr(phase[POFF_W-1 -: ADDR_W]), .sample_o(raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1  <= 1'b0;
      en_s2  <= 1'b0;
      amp_s1 <= '0;
      amp_s2 <= '0;
    end else begin
      en_s1  <= amp_en;
      amp_s1 <= amp;
      en_s2  <= en_s1;
      amp_s2 <= amp_s1;
    end
  end

  dds_amp_scale #(.IN_W(OUT_W), .AMP_W(AMP_W)) i_scale (
    .clk(clk), .rst_n(rst_n), .sample_i(raw), .en(en_s2), .amp(amp_s2),
    .sample_o(sample_o)
  );
endmodule

// File: rtl/dds4_core.sv
module dds4_core #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ACC_W  = dds4_pkg::DEF_ACC_W,
  parameter int unsigned POFF_W = dds4_pkg::DEF_POFF_W,
  parameter int unsigned ADDR_W = dds4_pkg::DEF_ADDR_W,
  parameter int unsigned AMP_W  = dds4_pkg::DEF_AMP_W,
  parameter int unsigned OUT_W  = dds4_pkg::DEF_OUT_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_clr,
  input  logic                  cfg_update,
  input  logic [NCH*ACC_W-1:0]  stage_ftw,
  input  logic [NCH*POFF_W-1:0] stage_pow,
  input  logic [NCH*AMP_W-1:0]  stage_amp,
  input  logic [NCH-1:0]        stage_amp_en,
  output logic [NCH*OUT_W-1:0]  sample_out
);
  logic [NCH*ACC_W-1:0]  act_ftw;
  logic [NCH*POFF_W-1:0] act_pow;
  logic [NCH*AMP_W-1:0]  act_amp;
  logic [NCH-1:0]        act_en;
  logic [NCH*ACC_W-1:0]  acc_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_ftw <= '0;
      act_pow <= '0;
      act_amp <= '0;
      act_en  <= '0;
    end else if (cfg_update) begin
      act_ftw <= stage_ftw;
      act_pow <= stage_pow;
      act_amp <= stage_amp;
      act_en  <= stage_amp_en;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic signed [OUT_W-1:0] smp;
    dds_channel #(
      .ACC_W(ACC_W), .POFF_W(POFF_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W), .OUT_W(OUT_W)
    ) i_ch (
      .clk(clk), .rst_n(rst_n), .clr(acc_clr),
      .ftw(act_ftw[c*ACC_W +: ACC_W]),
      .pow(act_pow[c*POFF_W +: POFF_W]),
      .amp_en(act_en[c]),
      .amp(act_amp[c*AMP_W +: AMP_W]),
      .acc_o(acc_all[c*ACC_W +: ACC_W]),
      .sample_o(smp)
    );
    assign sample_out[c*OUT_W +: OUT_W] = smp;
  end
endmodule

// File: rtl/dds4_chk.sv
module dds4_chk #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ACC_W  = 32,
  parameter int unsigned POFF_W = 14,
  parameter int unsigned AMP_W  = 10,
  parameter int unsigned OUT_W  = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  acc_clr,
  input logic                  cfg_update,
  input logic [NCH*ACC_W-1:0]  stage_ftw,
  input logic [NCH*POFF_W-1:0] stage_pow,
  input logic [NCH*AMP_W-1:0]  stage_amp,
  input logic [NCH-1:0]        stage_amp_en,
  input logic [NCH*ACC_W-1:0]  act_ftw,
  input logic [NCH*POFF_W-1:0] act_pow,
  input logic [NCH*AMP_W-1:0]  act_amp,
  input logic [NCH-1:0]        act_en,
  input logic [NCH*ACC_W-1:0]  acc_all,
  input logic [NCH*OUT_W-1:0]  sample_out
);
  // R7
  acc_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_clr |=> acc_all == '0);

  // R6
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_update |=> $stable(act_ftw) && $stable(act_pow) && $stable(act_amp) && $stable(act_en));

  // R6
  act_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_update |=> act_ftw == $past(stage_ftw) && act_pow == $past(stage_pow)
                   && act_amp == $past(stage_amp) && act_en == $past(stage_amp_en));

  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R1
    acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_clr |=> acc_all[c*ACC_W +: ACC_W] ==
        ACC_W'($past(acc_all[c*ACC_W +: ACC_W]) + $past(act_ftw[c*ACC_W +: ACC_W])));

    // R3
    sample_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sample_out[c*OUT_W +: OUT_W] != {1'b1, {(OUT_W-1){1'b0}}});
  end
endmodule

bind dds4_core dds4_chk #(
  .NCH(NCH), .ACC_W(ACC_W), .POFF_W(POFF_W), .AMP_W(AMP_W), .OUT_W(OUT_W)
) i_dds4_chk (
  .clk(clk), .rst_n(rst_n), .acc_clr(acc_clr), .cfg_update(cfg_update),
  .stage_ftw(stage_ftw), .stage_pow(stage_pow), .stage_amp(stage_amp),
  .stage_amp_en(stage_amp_en), .act_ftw(act_ftw), .act_pow(act_pow),
  .act_amp(act_amp), .act_en(act_en), .acc_all(acc_all), .sample_out(sample_out)
);

// File: tb/test_dds4_core.sv
`timescale 1ns/1ps
module test_dds4_core;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         acc_clr;
  logic         cfg_update;
  logic [127:0] stage_ftw;
  logic [55:0]  stage_pow;
  logic [39:0]  stage_amp;
  logic [3:0]   stage_amp_en;
  logic [39:0]  sample_out;

  int n_chk = 0;
  int n_err = 0;

  logic [31:0] m_ftw [4];
  logic [13:0] m_pow [4];
  logic [9:0]  m_amp [4];
  logic        m_en  [4];

  always #4 clk = ~clk;

  dds4_core i_dds4_core (
    .clk(clk), .rst_n(rst_n), .acc_clr(acc_clr), .cfg_update(cfg_update),
    .stage_ftw(stage_ftw), .stage_pow(stage_pow), .stage_amp(stage_amp),
    .stage_amp_en(stage_amp_en), .sample_out(sample_out)
  );

  function automatic int model(logic [31:0] acc, logic [13:0] pw, logic en, logic [9:0] am);
    logic [13:0] ph;
    logic [11:0] a;
    int k;
    int idx;
    int mag;
    ph  = acc[31:18] + pw;
    a   = ph[13:2];
    k   = int'(a[9:0]);
    idx = a[10] ? 1023 - k : k;
    mag = $rtoi($floor(511.0 * $sin(3.141592653589793 * (2.0 * idx + 1.0) / 4096.0) + 0.5));
    if (en) mag = (mag * int'(am)) >>> 10;
    return a[11] ? -mag : mag;
  endfunction

  function automatic int out_of(int c);
    return int'($signed(sample_out[c*10 +: 10]));
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_stage();
    for (int c = 0; c < 4; c++) begin
      stage_ftw[c*32 +: 32] = m_ftw[c];
      stage_pow[c*14 +: 14] = m_pow[c];
      stage_amp[c*10 +: 10] = m_amp[c];
      stage_amp_en[c]       = m_en[c];
    end
  endtask

  // Load settings, clear accumulators, then compare every cycle.
  task automatic run_round(string tag, bit eq01, bit junk);
    @(negedge clk);
    drive_stage();
    cfg_update = 1'b1;
    @(negedge clk);
    cfg_update = 1'b0;
    acc_clr = 1'b1;
    @(negedge clk);
    acc_clr = 1'b0;
    for (int j = 1; j <= 40; j++) begin
      @(negedge clk);
      if (j >= 3) begin
        for (int c = 0; c < 4; c++) begin
          logic [31:0] a;
          a = 32'(m_ftw[c] * 32'(j - 3));
          // R1 R2 R3 R4 R5 R7 R8 against model
          chk($sformatf("R8 %s ch%0d cyc%0d", tag, c, j), out_of(c),
              model(a, m_pow[c], m_en[c], m_amp[c]));
        end
        if (eq01) chk($sformatf("R8 coherent %s cyc%0d", tag, j), out_of(0), out_of(1));
      end
      if (junk && j == 15) begin
        // R6: staged change without update must not reach the outputs
        stage_ftw    = {$urandom, $urandom, $urandom, $urandom};
        stage_pow    = {$urandom, $urandom};
        stage_amp    = {$urandom, $urandom};
        stage_amp_en = 4'($urandom);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R8 watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0;
    acc_clr = 1'b0;
    cfg_update = 1'b0;
    stage_ftw = '0;
    stage_pow = '0;
    stage_amp = '0;
    stage_amp_en = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) chk($sformatf("R9 reset ch%0d", c), out_of(c), 0);

    // Directed: fixed phases, scale bypass and scale values (R3 R4 R5)
    m_ftw = '{32'd0, 32'd0, 32'd0, 32'd0};
    m_pow = '{14'h1000, 14'h1000, 14'h3000, 14'h1000};
    m_en  = '{1'b0, 1'b1, 1'b1, 1'b1};
    m_amp = '{10'h155, 10'h3FF, 10'h200, 10'h000};
    run_round("const", 1'b0, 1'b0);
    chk("R4 bypass peak", out_of(0), 511);
    chk("R5 full scale", out_of(1), 510);
    chk("R5 half scale negative", out_of(2), -255);
    chk("R5 zero scale", out_of(3), 0);

    // Directed: quarter/half turn steps and all-ones wrap (R1 R2)
    m_ftw = '{32'h4000_0000, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0123_4567};
    m_pow = '{14'h0, 14'h0, 14'h2000, 14'h0800};
    m_en  = '{1'b0, 1'b0, 1'b0, 1'b1};
    m_amp = '{10'h3FF, 10'h0, 10'h0, 10'h155};
    run_round("steps", 1'b0, 1'b0);

    // Random, channels 0 and 1 equal, staged junk without update (R6 R8)
    for (int c = 0; c < 4; c++) begin
      m_ftw[c] = $urandom;
      m_pow[c] = 14'($urandom);
      m_amp[c] = 10'($urandom);
      m_en[c]  = 1'($urandom);
    end
    m_ftw[1] = m_ftw[0];
    m_pow[1] = m_pow[0];
    m_amp[1] = m_amp[0];
    m_en[1]  = m_en[0];
    run_round("equal", 1'b1, 1'b1);

    for (int r = 0; r < 5; r++) begin
      for (int c = 0; c < 4; c++) begin
        m_ftw[c] = $urandom;
        m_pow[c] = 14'($urandom);
        m_amp[c] = 10'($urandom);
        m_en[c]  = 1'($urandom);
      end
      run_round($sformatf("rand%0d", r), 1'b0, r == 2);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule